// File: doc/BRIEF.md
# Privileged Instruction Trap Checker

This block judges three families of privileged instructions: wait-for-interrupt, the supervisor address-translation fence, and the two hypervisor fences (virtual-address and guest-physical). For each request it chooses one of three verdicts. The instruction may execute, which raises a halt request for wait-for-interrupt or a flush request for a fence. It may instead raise an illegal-instruction exception, or a virtual-instruction fault. An exception strobe always comes with its cause code.

A request captures the instruction class together with the hart's privilege, the virtualization bit, the trap-enable status bits (wait timeout, translation-management trap, and their guest counterparts) and the two extension-present flags. The block holds all of these in one register stage. The verdict is decoded combinationally from that stage, so the result is visible during the cycle that follows the request. The flush itself and the wake-up logic sit outside this block.

Top module: `trap_checker`

## Requirements
- R1: After reset, and in any cycle that does not follow a request, res_valid, exec_halt, exec_flush, trap_illegal and trap_virtual are all 0 and trap_cause is 0.
- R2: res_valid is 1 exactly in the cycle after req_valid was 1, and in that cycle exactly one of exec_halt, exec_flush, trap_illegal, trap_virtual is 1. The class codes are 0 for wait-for-interrupt, 1 for the supervisor fence, 2 for the virtual-address hypervisor fence and 3 for the guest-physical hypervisor fence. The privilege codes are 0 for U, 1 for S and 3 for M.
- R3: Wait-for-interrupt traps as illegal in two cases. The first is wait-timeout set with the hart in S mode, or in U mode on a hart without S mode. The second is a hart with S mode that is in U mode while not virtualized.
- R4: Wait-for-interrupt that escapes R3 raises a virtual-instruction fault when the hart is virtualized and is either in U mode or in S mode with the guest wait-timeout bit set.
- R5: Wait-for-interrupt that escapes R3 and R4 asserts exec_halt.
- R6: The supervisor fence traps as illegal in U mode, and in S mode when the translation-management trap bit is set.
- R7: A supervisor fence that escapes R6 raises a virtual-instruction fault when the hypervisor extension is present, the hart is virtualized and the guest translation-management trap bit is set. Otherwise it asserts exec_flush.
- R8: Either hypervisor fence executed in S mode while virtualized raises a virtual-instruction fault.
- R9: A hypervisor fence that escapes R8 and R10 flushes in M mode or in non-virtualized S mode, and traps as illegal in every other case.
- R10: The guest-physical hypervisor fence traps as illegal in non-virtualized S mode when the translation-management trap bit is set. This check runs ahead of R8 and R9.
- R11: trap_cause is 2 with trap_illegal, 22 with trap_virtual, and 0 otherwise.
- R12: The verdict depends only on the values present with the request. Changing any input in the result cycle leaves the outputs of that cycle unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | Instruction class (0 wfi, 1 sfence, 2 hfence-v, 3 hfence-g) |
| req_priv | input | 2 | Current privilege (0 U, 1 S, 3 M) |
| req_virt | input | 1 | Hart is virtualized |
| req_tw | input | 1 | Wait-timeout trap enable |
| req_tvm | input | 1 | Translation-management trap enable |
| req_vtw | input | 1 | Guest wait-timeout trap enable |
| req_vtvm | input | 1 | Guest translation-management trap enable |
| req_has_s | input | 1 | Hart implements S mode |
| req_has_h | input | 1 | Hart implements the hypervisor extension |
| res_valid | output | 1 | Verdict present this cycle |
| exec_halt | output | 1 | Halt request (wait-for-interrupt allowed) |
| exec_flush | output | 1 | Flush request (fence allowed) |
| trap_illegal | output | 1 | Illegal-instruction exception |
| trap_virtual | output | 1 | Virtual-instruction fault |
| trap_cause | output | 5 | Exception cause code |

## Verification
The bench sweeps every class against the three legal privileges and all 128 combinations of the seven flag bits. This covers the precedence corners, where a design that reversed the order of the checks would report a virtual fault where an illegal trap belongs. Examples are wait-for-interrupt in virtualized U mode on a hart without S mode but with wait-timeout set, and the guest-physical fence in non-virtualized S mode with the translation-management bit set. The M-mode supervisor fence with the guest bits set checks that the guest check is not gated by privilege. The bench also confirms that status bits changed in the result cycle do not leak into the verdict, and that back-to-back requests each produce a single-cycle strobe.

// File: rtl/privtrap_pkg.sv
package privtrap_pkg;

  localparam logic [1:0] OP_WFI      = 2'd0;
  localparam logic [1:0] OP_SFENCE   = 2'd1;
  localparam logic [1:0] OP_HFENCE_V = 2'd2;
  localparam logic [1:0] OP_HFENCE_G = 2'd3;

  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  typedef enum logic [1:0] {
    VERD_EXEC    = 2'd0,
    VERD_ILLEGAL = 2'd1,
    VERD_VIRTUAL = 2'd2
  } verdict_e;

  typedef struct packed {
    logic [1:0] op;
    logic [1:0] priv;
    logic       virt;
    logic       tw;
    logic       tvm;
    logic       vtw;
    logic       vtvm;
    logic       has_s;
    logic       has_h;
  } req_t;

  function automatic verdict_e judge_wfi(input req_t r);
    logic in_u, in_s, ill, vf;
    in_u = (r.priv == PRIV_U);
    in_s = (r.priv == PRIV_S);
    ill  = (r.tw && (in_s || (in_u && !r.has_s))) ||
           (r.has_s && in_u && !r.virt);
    vf   = r.virt && (in_u || (in_s && r.vtw));
    if (ill)     return VERD_ILLEGAL;
    else if (vf) return VERD_VIRTUAL;
    else         return VERD_EXEC;
  endfunction

  function automatic verdict_e judge_sfence(input req_t r);
    logic below_s, ill, vf;
    below_s = (r.priv == PRIV_U);
    ill     = below_s || ((r.priv == PRIV_S) && r.tvm);
    vf      = r.has_h && r.virt && r.vtvm;
    if (ill)     return VERD_ILLEGAL;
    else if (vf) return VERD_VIRTUAL;
    else         return VERD_EXEC;
  endfunction

  function automatic verdict_e judge_hfence(input req_t r, input logic guest_phys);
    logic in_s, pre_ill;
    in_s    = (r.priv == PRIV_S);
    pre_ill = guest_phys && in_s && !r.virt && r.tvm;
    if (pre_ill)                              return VERD_ILLEGAL;
    else if (in_s && r.virt)                  return VERD_VIRTUAL;
    else if ((r.priv == PRIV_M) || in_s)      return VERD_EXEC;
    else                                      return VERD_ILLEGAL;
  endfunction

endpackage

// File: rtl/privtrap_req_stage.sv
module privtrap_req_stage
  import privtrap_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  req_t in_req,
  output logic held_valid,
  output req_t held_req
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_valid <= 1'b0;
      held_req   <= '0;
    end else begin
      held_valid <= in_valid;
      if (in_valid) held_req <= in_req;
    end
  end

endmodule

// File: rtl/privtrap_decide.sv
module privtrap_decide
  import privtrap_pkg::*;
(
  input  req_t     req,
  output verdict_e verdict,
  output verdict_e wfi_verdict,
  output verdict_e sfence_verdict,
  output verdict_e hfence_verdict
);

  assign wfi_verdict    = judge_wfi(req);
  assign sfence_verdict = judge_sfence(req);
  assign hfence_verdict = judge_hfence(req, req.op == OP_HFENCE_G);

  always_comb begin
    case (req.op)
      OP_WFI:    verdict = wfi_verdict;
      OP_SFENCE: verdict = sfence_verdict;
      default:   verdict = hfence_verdict;
    endcase
  end

endmodule

// File: rtl/privtrap_outcome.sv
module privtrap_outcome
  import privtrap_pkg::*;
#(
  parameter int CAUSE_W      = 5,
  parameter int ILLEGAL_CODE = 2,
  parameter int VIRTUAL_CODE = 22
) (
  input  logic               valid,
  input  logic [1:0]         op,
  input  verdict_e           verdict,
  output logic               halt,
  output logic               flush,
  output logic               illegal,
  output logic               virtual_fault,
  output logic [CAUSE_W-1:0] cause
);

  localparam logic [CAUSE_W-1:0] ILL_C = CAUSE_W'(ILLEGAL_CODE);
  localparam logic [CAUSE_W-1:0] VRT_C = CAUSE_W'(VIRTUAL_CODE);

  logic pass;
  assign pass          = valid && (verdict == VERD_EXEC);
  assign halt          = pass && (op == OP_WFI);
  assign flush         = pass && (op != OP_WFI);
  assign illegal       = valid && (verdict == VERD_ILLEGAL);
  assign virtual_fault = valid && (verdict == VERD_VIRTUAL);

  always_comb begin
    if (illegal)            cause = ILL_C;
    else if (virtual_fault) cause = VRT_C;
    else                    cause = '0;
  end

endmodule

// File: rtl/trap_checker.sv
module trap_checker
  import privtrap_pkg::*;
#(
  parameter int CAUSE_W      = 5,
  parameter int ILLEGAL_CODE = 2,
  parameter int VIRTUAL_CODE = 22
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [1:0]         req_op,
  input  logic [1:0]         req_priv,
  input  logic               req_virt,
  input  logic               req_tw,
  input  logic               req_tvm,
  input  logic               req_vtw,
  input  logic               req_vtvm,
  input  logic               req_has_s,
  input  logic               req_has_h,
  output logic               res_valid,
  output logic               exec_halt,
  output logic               exec_flush,
  output logic               trap_illegal,
  output logic               trap_virtual,
  output logic [CAUSE_W-1:0] trap_cause
);

  req_t     in_req, held_req;
  logic     held_valid;
  verdict_e verdict, wfi_v, sfence_v, hfence_v;

  assign in_req = '{op: req_op, priv: req_priv, virt: req_virt, tw: req_tw,
                    tvm: req_tvm, vtw: req_vtw, vtvm: req_vtvm,
                    has_s: req_has_s, has_h: req_has_h};

  privtrap_req_stage u_stage (
    .clk(clk), .rst_n(rst_n), .in_valid(req_valid), .in_req(in_req),
    .held_valid(held_valid), .held_req(held_req)
  );

  privtrap_decide u_decide (
    .req(held_req), .verdict(verdict), .wfi_verdict(wfi_v),
    .sfence_verdict(sfence_v), .hfence_verdict(hfence_v)
  );

  privtrap_outcome #(
    .CAUSE_W(CAUSE_W), .ILLEGAL_CODE(ILLEGAL_CODE), .VIRTUAL_CODE(VIRTUAL_CODE)
  ) u_outcome (
    .valid(held_valid), .op(held_req.op), .verdict(verdict),
    .halt(exec_halt), .flush(exec_flush), .illegal(trap_illegal),
    .virtual_fault(trap_virtual), .cause(trap_cause)
  );

  assign res_valid = held_valid;

endmodule

// File: rtl/trap_checker_sva.sv
module trap_checker_sva #(
  parameter int CAUSE_W = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic [1:0]         req_op,
  input logic [1:0]         req_priv,
  input logic               req_virt,
  input logic               res_valid,
  input logic               exec_halt,
  input logic               exec_flush,
  input logic               trap_illegal,
  input logic               trap_virtual,
  input logic [CAUSE_W-1:0] trap_cause
);

  logic any_out;
  assign any_out = exec_halt | exec_flush | trap_illegal | trap_virtual;

  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(req_valid)) |-> (!res_valid && !any_out && trap_cause == '0));

  p_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (res_valid == $past(req_valid)));

  p_single_outcome_r2: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ($countones({exec_halt, exec_flush, trap_illegal, trap_virtual}) == 1));

  p_halt_only_wfi_r5: assert property (@(posedge clk) disable iff (!rst_n)
    exec_halt |-> ($past(req_op) == 2'd0));

  p_user_sfence_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(req_valid) && $past(req_op) == 2'd1 && $past(req_priv) == 2'd0)
      |-> trap_illegal);

  p_virtual_needs_virt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    trap_virtual |-> $past(req_virt));

  p_hfence_machine_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(req_valid) && $past(req_op[1]) && $past(req_priv) == 2'd3)
      |-> exec_flush);

  p_cause_ill_r11: assert property (@(posedge clk) disable iff (!rst_n)
    trap_illegal |-> (trap_cause == CAUSE_W'(2)));

  p_cause_virt_r11: assert property (@(posedge clk) disable iff (!rst_n)
    trap_virtual |-> (trap_cause == CAUSE_W'(22)));

  p_cause_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!trap_illegal && !trap_virtual) |-> (trap_cause == '0));

endmodule

bind trap_checker trap_checker_sva #(.CAUSE_W(CAUSE_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
  .req_priv(req_priv), .req_virt(req_virt), .res_valid(res_valid),
  .exec_halt(exec_halt), .exec_flush(exec_flush), .trap_illegal(trap_illegal),
  .trap_virtual(trap_virtual), .trap_cause(trap_cause)
);

// File: tb/trap_checker_bench.sv
`timescale 1ns/1ps
module trap_checker_bench;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n, req_valid, req_virt, req_tw, req_tvm, req_vtw, req_vtvm, req_has_s, req_has_h;
  logic [1:0] req_op, req_priv;
  logic       res_valid, exec_halt, exec_flush, trap_illegal, trap_virtual;
  logic [4:0] trap_cause;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  trap_checker u_trap_checker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_priv(req_priv), .req_virt(req_virt), .req_tw(req_tw), .req_tvm(req_tvm),
    .req_vtw(req_vtw), .req_vtvm(req_vtvm), .req_has_s(req_has_s),
    .req_has_h(req_has_h), .res_valid(res_valid), .exec_halt(exec_halt),
    .exec_flush(exec_flush), .trap_illegal(trap_illegal),
    .trap_virtual(trap_virtual), .trap_cause(trap_cause)
  );

  // observed outcome packed as {valid, halt, flush, illegal, virtual, cause}
  function automatic logic [9:0] observed();
    return {res_valid, exec_halt, exec_flush, trap_illegal, trap_virtual, trap_cause};
  endfunction

  // kind: 0 halt, 1 flush, 2 illegal, 3 virtual
  function automatic logic [9:0] pack_kind(input int kind);
    case (kind)
      0: return {5'b11000, 5'd0};
      1: return {5'b10100, 5'd0};
      2: return {5'b10010, 5'd2};
      default: return {5'b10001, 5'd22};
    endcase
  endfunction

  task automatic check(input string req, input logic [9:0] got, input logic [9:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, got, exp);
    end
  endtask

  // expected kind and the requirement that decides it
  task automatic expect_of(input int op, input int pv, input bit v, input bit tw, input bit tvm,
                           input bit vtw, input bit vtvm, input bit hs, input bit hh,
                           output int kind, output string tag);
    bit u, s, m;
    u = (pv == 0); s = (pv == 1); m = (pv == 3);
    if (op == 0) begin
      if (s && tw)             begin kind = 2; tag = "R3 wfi tw in S"; end
      else if (u && !hs && tw) begin kind = 2; tag = "R3 wfi tw in U no S"; end
      else if (u && hs && !v)  begin kind = 2; tag = "R3 wfi U with S"; end
      else if (v && u)         begin kind = 3; tag = "R4 wfi virt U"; end
      else if (v && s && vtw)  begin kind = 3; tag = "R4 wfi virt S vtw"; end
      else                     begin kind = 0; tag = "R5 wfi halt"; end
    end else if (op == 1) begin
      if (u || (s && tvm))     begin kind = 2; tag = "R6 sfence illegal"; end
      else if (hh && v && vtvm) begin kind = 3; tag = "R7 sfence virtual"; end
      else                     begin kind = 1; tag = "R7 sfence flush"; end
    end else begin
      if (op == 3 && s && !v && tvm) begin kind = 2; tag = "R10 gvma tvm"; end
      else if (s && v)         begin kind = 3; tag = "R8 hfence virt S"; end
      else if (m || s)         begin kind = 1; tag = "R9 hfence flush"; end
      else                     begin kind = 2; tag = "R9 hfence illegal"; end
    end
  endtask

  task automatic drive(input int op, input int pv, input logic [6:0] f);
    req_op = 2'(op); req_priv = 2'(pv);
    {req_virt, req_tw, req_tvm, req_vtw, req_vtvm, req_has_s, req_has_h} = f;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int kind;
    string tag;
    rst_n = 1'b0; req_valid = 1'b0;
    drive(0, 0, 7'd0);
    repeat (3) @(negedge clk);
    check("R1 reset state", observed(), 10'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", observed(), 10'd0);

    // exhaustive sweep over class, privilege and flag bits
    for (int op = 0; op < 4; op++) begin
      for (int pi = 0; pi < 3; pi++) begin
        for (int f = 0; f < 128; f++) begin
          int pv;
          logic [6:0] fb;
          pv = (pi == 2) ? 3 : pi;
          fb = 7'(f);
          @(negedge clk);
          drive(op, pv, fb);
          req_valid = 1'b1;
          @(negedge clk);
          req_valid = 1'b0;
          expect_of(op, pv, fb[6], fb[5], fb[4], fb[3], fb[2], fb[1], fb[0], kind, tag);
          check(tag, observed(), pack_kind(kind));
          @(negedge clk);
          check("R1 idle between requests", observed(), 10'd0);
        end
      end
    end

    // R11: the two cause codes seen directly
    @(negedge clk); drive(1, 0, 7'd0); req_valid = 1'b1;
    @(negedge clk); req_valid = 1'b0;
    check("R11 illegal cause 2", {5'd0, trap_cause}, {5'd0, 5'd2});
    @(negedge clk); drive(2, 1, 7'b1000000); req_valid = 1'b1;
    @(negedge clk); req_valid = 1'b0;
    check("R11 virtual cause 22", {5'd0, trap_cause}, {5'd0, 5'd22});

    // R12: inputs flipped in the result cycle do not alter the verdict
    @(negedge clk); drive(0, 3, 7'd0); req_valid = 1'b1;
    @(negedge clk); req_valid = 1'b0; drive(1, 0, 7'b1111111);
    #1 check("R12 wfi in M held", observed(), pack_kind(0));
    @(negedge clk); drive(3, 1, 7'b0010000); req_valid = 1'b1;
    @(negedge clk); req_valid = 1'b0; drive(0, 3, 7'b1000000);
    #1 check("R12 gvma held", observed(), pack_kind(2));

    // R2: back-to-back requests give one verdict per cycle
    @(negedge clk); drive(1, 3, 7'd0); req_valid = 1'b1;
    @(negedge clk); check("R2 b2b first flush", observed(), pack_kind(1));
    drive(0, 1, 7'b1001000);
    @(negedge clk); req_valid = 1'b0;
    check("R2 b2b second virtual", observed(), pack_kind(3));
    @(negedge clk); check("R2 strobe drops", observed(), 10'd0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule